// File: doc/BRIEF.md
# Legacy Shadow Window Decoder

This block decides where each memory access in the legacy area between 0xA0000 and 0xFFFFF goes. Every access goes either to system DRAM or out to the PCI bus. For read-only regions the block also decides whether a write may reach DRAM. The choice is driven by a small byte-addressed configuration space. Seven attribute bytes give each of thirteen uneven shadow regions a 2-bit attribute. A separate control byte, together with the system-management mode input, sets whether the 128 KiB system-management RAM window is visible. The configuration space also contains a read-only byte that reports the installed memory size.

An access is presented for one cycle with `req_valid`, `req_write` and `req_addr`. One cycle later the block raises exactly one of `dram_sel` (route to DRAM), `pci_sel` (forward to PCI) or `wr_block` (write dropped). Configuration bytes are written one at a time through `cfg_we`, `cfg_addr` and `cfg_wdata`. They are read back combinationally on `cfg_rdata`. The mode input `smm_in` may change at any time relative to the clock.

Top module: `shadow_decoder`

## Requirements
- R1: After reset, config bytes 0x59 to 0x5F read 0x00, byte 0x72 reads 0x02, and `dram_sel`, `pci_sel` and `wr_block` are low.
- R2: Addresses 0xF0000 to 0xFFFFF form one 64 KiB region. Its attribute is bits 5:4 of byte 0x59; bits 1:0 of that byte do not affect it.
- R3: Twelve 16 KiB regions, numbered n = 0 to 11, start at 0xC0000 + n*0x4000. Region n takes its attribute from byte 0x5A + (n>>1): bits 1:0 when n is even, bits 5:4 when n is odd.
- R4: Attribute 3 routes reads and writes to DRAM. Attributes 0 and 2 forward reads and writes to PCI.
- R5: Attribute 1 routes reads to DRAM. A write to such a region raises `wr_block` for one cycle, with `dram_sel` and `pci_sel` low.
- R6: Addresses 0xA0000 to 0xBFFFF route to DRAM when (the synchronised mode input is high AND bit 3 of byte 0x72 is set) OR bit 6 of byte 0x72 is set. Otherwise they forward to PCI. This holds for reads and writes alike.
- R7: `smm_in` passes through a two-flop synchroniser. A change first affects a request sampled on the third rising edge after the change.
- R8: An address below 0xA0000 or above 0xFFFFF always routes to DRAM, whatever the configuration.
- R9: Byte 0x57 reads min(MEM_MIB/8, 255) and ignores writes.
- R10: The outputs are registered. They respond on the cycle after a request is sampled, at most one of them is high, and all are low on a cycle after no request.
- R11: A configuration write affects a request sampled on the very next rising edge.
- R12: Config bytes outside 0x57, 0x59 to 0x5F and 0x72 read as 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_in | input | 1 | System-management mode indication, asynchronous |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 8 | Config byte address |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data for `cfg_addr` |
| req_valid | input | 1 | Memory access present this cycle |
| req_write | input | 1 | Access is a write |
| req_addr | input | ADDR_W | Byte address of the access |
| dram_sel | output | 1 | Access routed to DRAM |
| pci_sel | output | 1 | Access forwarded to PCI |
| wr_block | output | 1 | Write to a read-only region dropped |

## Verification
The assertions assume that `req_write` has meaning only while `req_valid` is high. They also assume that the configuration changes only through `cfg_we`, one byte per cycle. The bench holds every input steady from one falling edge to the next, so each request and each config write is seen on exactly one rising edge. It changes `smm_in` only at falling edges. It counts the synchroniser edges itself and does not wait an arbitrary time, so the check of R7 does not depend on metastability.

// File: rtl/shadow_pkg.sv
// Shared constants and types for the legacy shadow window decoder.
// Assumes byte-wide configuration addressing with an 8-bit config address.
package shadow_pkg;

    // 2-bit region attribute encoding
    typedef enum logic [1:0] {
        ATTR_BUS_A = 2'd0,
        ATTR_RO    = 2'd1,
        ATTR_BUS_B = 2'd2,
        ATTR_RW    = 2'd3
    } attr_e;

    // decoded destination of one access
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_DRAM  = 2'd1,
        TGT_PCI   = 2'd2,
        TGT_BLOCK = 2'd3
    } tgt_e;

    localparam logic [7:0] ATTR_BASE   = 8'h59;
    localparam int         ATTR_BYTES  = 7;
    localparam logic [7:0] SMC_ADDR    = 8'h72;
    localparam logic [7:0] SMC_RESET   = 8'h02;
    localparam logic [7:0] MSZ_ADDR    = 8'h57;
    localparam int         SMC_OPEN_B  = 6;
    localparam int         SMC_MODE_B  = 3;
    localparam int         NUM_SUB     = 12;

endpackage

// File: rtl/shd_sync.sv
// Multi-stage synchroniser for a single asynchronous level.
// Assumes the input is a level that stays put for several clocks.
module shd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/shd_cfg_regs.sv
// Configuration byte space: seven attribute bytes, the SMRAM control byte
// and a read-only memory-size byte. Bytes are written one at a time;
// read data is combinational on the address.
module shd_cfg_regs
    import shadow_pkg::*;
#(
    parameter int MEM_MIB = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [7:0]                cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic [1:0]                top_attr,
    output logic [NUM_SUB-1:0][1:0]   sub_attr,
    output logic                      smram_open,
    output logic                      smram_mode_en
);
    localparam int         UNITS   = MEM_MIB / 8;
    localparam logic [7:0] MSZ_VAL = (UNITS > 255) ? 8'd255 : 8'(UNITS);

    logic [7:0] attr_q [ATTR_BYTES];
    logic [7:0] smc_q;

    // one register per attribute byte
    for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
        localparam logic [7:0] MY_ADDR = ATTR_BASE + 8'(g);
        // load the byte when its own address is written
        always_ff @(posedge clk) begin
            if (!rst_n)                              attr_q[g] <= 8'h00;
            else if (cfg_we && cfg_addr == MY_ADDR)  attr_q[g] <= cfg_wdata;
        end
    end

    // SMRAM control byte
    always_ff @(posedge clk) begin
        if (!rst_n)                               smc_q <= SMC_RESET;
        else if (cfg_we && cfg_addr == SMC_ADDR)  smc_q <= cfg_wdata;
    end

    assign top_attr = attr_q[0][5:4];

    // pick each small region's nibble: even index low pair, odd index high pair
    for (genvar n = 0; n < NUM_SUB; n++) begin : g_sub
        if (n % 2 == 0) begin : g_even
            assign sub_attr[n] = attr_q[1 + n/2][1:0];
        end else begin : g_odd
            assign sub_attr[n] = attr_q[1 + n/2][5:4];
        end
    end

    assign smram_open    = smc_q[SMC_OPEN_B];
    assign smram_mode_en = smc_q[SMC_MODE_B];

    // read mux over the implemented bytes, zero elsewhere
    always_comb begin
        cfg_rdata = 8'h00;
        for (int k = 0; k < ATTR_BYTES; k++) begin
            if (cfg_addr == ATTR_BASE + 8'(k)) cfg_rdata = attr_q[k];
        end
        if (cfg_addr == SMC_ADDR) cfg_rdata = smc_q;
        if (cfg_addr == MSZ_ADDR) cfg_rdata = MSZ_VAL;
    end
endmodule

// File: rtl/shd_region_decode.sv
// Combinational address decode: classifies the address into the SMRAM
// window, the 64 KiB top region, one of twelve 16 KiB regions or outside,
// and turns the applicable control into a destination.
// Assumes ADDR_W >= 20.
module shd_region_decode
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     is_write,
    input  logic [1:0]               top_attr,
    input  logic [NUM_SUB-1:0][1:0]  sub_attr,
    input  logic                     smram_open,
    input  logic                     smram_mode_en,
    input  logic                     smm_mode,
    output tgt_e                     tgt
);
    logic       hi_zero;
    logic       in_smram, in_top, in_sub;
    logic [3:0] sub_idx;
    logic [1:0] sel_attr;

    if (ADDR_W > 20) begin : g_hi
        assign hi_zero = ~|addr[ADDR_W-1:20];
    end else begin : g_nohi
        assign hi_zero = 1'b1;
    end

    assign in_smram = hi_zero && (addr[19:17] == 3'b101);
    assign in_top   = hi_zero && (addr[19:16] == 4'hF);
    assign in_sub   = hi_zero && (addr[19:18] == 2'b11) && !in_top;
    assign sub_idx  = addr[17:14];

    // select the attribute that governs this address
    always_comb begin
        sel_attr = top_attr;
        if (!in_top) begin
            sel_attr = 2'd0;
            for (int k = 0; k < NUM_SUB; k++) begin
                if (sub_idx == 4'(k)) sel_attr = sub_attr[k];
            end
        end
    end

    // turn window membership and control state into a destination
    always_comb begin
        if (in_smram) begin
            tgt = ((smm_mode && smram_mode_en) || smram_open) ? TGT_DRAM : TGT_PCI;
        end else if (in_top || in_sub) begin
            case (attr_e'(sel_attr))
                ATTR_RW: tgt = TGT_DRAM;
                ATTR_RO: tgt = is_write ? TGT_BLOCK : TGT_DRAM;
                default: tgt = TGT_PCI;
            endcase
        end else begin
            tgt = TGT_DRAM;
        end
    end
endmodule

// File: rtl/shadow_decoder.sv
// Top of the legacy shadow window decoder. Synchronises the mode input,
// holds the configuration bytes, decodes each access and registers the
// one-hot routing result one cycle after the request.
module shadow_decoder
    import shadow_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MEM_MIB     = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smm_in,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dram_sel,
    output logic              pci_sel,
    output logic              wr_block
);
    logic                     smm_s;
    logic [1:0]               top_attr;
    logic [NUM_SUB-1:0][1:0]  sub_attr;
    logic                     smram_open;
    logic                     smram_mode_en;
    tgt_e                     tgt;

    shd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (smm_in),
        .q_sync  (smm_s)
    );

    shd_cfg_regs #(.MEM_MIB(MEM_MIB)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .top_attr      (top_attr),
        .sub_attr      (sub_attr),
        .smram_open    (smram_open),
        .smram_mode_en (smram_mode_en)
    );

    shd_region_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr          (req_addr),
        .is_write      (req_write),
        .top_attr      (top_attr),
        .sub_attr      (sub_attr),
        .smram_open    (smram_open),
        .smram_mode_en (smram_mode_en),
        .smm_mode      (smm_s),
        .tgt           (tgt)
    );

    // register the routing decision for the sampled request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_sel <= 1'b0;
            pci_sel  <= 1'b0;
            wr_block <= 1'b0;
        end else begin
            dram_sel <= req_valid && (tgt == TGT_DRAM);
            pci_sel  <= req_valid && (tgt == TGT_PCI);
            wr_block <= req_valid && (tgt == TGT_BLOCK);
        end
    end
endmodule

// File: rtl/shd_checker.sv
// Protocol checks for shadow_decoder, attached by bind.
module shd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              dram_sel,
    input logic              pci_sel,
    input logic              wr_block,
    input logic              smram_open
);
    logic outside, in_smram;
    assign outside  = (req_addr < ADDR_W'(20'hA0000)) || (req_addr > ADDR_W'(20'hFFFFF));
    assign in_smram = (req_addr >= ADDR_W'(20'hA0000)) && (req_addr <= ADDR_W'(20'hBFFFF));

    // R10
    one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_sel, pci_sel, wr_block}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dram_sel && !pci_sel && !wr_block);

    // R5
    read_no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> !wr_block);

    // R8
    outside_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && outside |=> dram_sel);

    // R6
    smram_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_smram && smram_open |=> dram_sel);
endmodule

bind shadow_decoder shd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .dram_sel   (dram_sel),
    .pci_sel    (pci_sel),
    .wr_block   (wr_block),
    .smram_open (smram_open)
);

// File: tb/sim_shadow_decoder.sv
module sim_shadow_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smm_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        dram_sel, pci_sel, wr_block;
    logic [7:0]  sat_rdata;
    logic        sat_d, sat_p, sat_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] m_attr [7];
    logic [7:0] m_smc;
    logic       m_smm;

    always #2.5 clk = ~clk;

    shadow_decoder u0 (
        .clk(clk), .rst_n(rst_n), .smm_in(smm_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .dram_sel(dram_sel), .pci_sel(pci_sel), .wr_block(wr_block)
    );

    shadow_decoder #(.MEM_MIB(4096)) u_sat (
        .clk(clk), .rst_n(rst_n), .smm_in(1'b0),
        .cfg_we(1'b0), .cfg_addr(8'h57), .cfg_wdata(8'h00), .cfg_rdata(sat_rdata),
        .req_valid(1'b0), .req_write(1'b0), .req_addr(32'h0),
        .dram_sel(sat_d), .pci_sel(sat_p), .wr_block(sat_b)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // expected {dram,pci,block} from the requirements
    function automatic logic [2:0] model(input logic [31:0] a, input logic w);
        logic [1:0] at;
        int n;
        if (a >= 32'hF0000 && a <= 32'hFFFFF) at = m_attr[0][5:4];
        else if (a >= 32'hC0000 && a < 32'hF0000) begin
            n = int'((a - 32'hC0000) / 32'h4000);
            at = (n % 2 == 0) ? m_attr[1 + n/2][1:0] : m_attr[1 + n/2][5:4];
        end else if (a >= 32'hA0000 && a < 32'hC0000)
            return ((m_smm && m_smc[3]) || m_smc[6]) ? 3'b100 : 3'b010;
        else return 3'b100;
        case (at)
            2'd3:    return 3'b100;
            2'd1:    return w ? 3'b001 : 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    // tasks start at a falling edge and end at a falling edge
    task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 8'h59 && a <= 8'h5F) m_attr[a - 8'h59] = d;
        if (a == 8'h72) m_smc = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic w);
        logic [2:0] e;
        e = model(a, w);
        req_valid = 1'b1; req_write = w; req_addr = a;
        @(posedge clk); #1;
        check(req, {5'd0, dram_sel, pci_sel, wr_block}, {5'd0, e});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 outputs", {5'd0, dram_sel, pci_sel, wr_block}, 8'h00);
        for (int k = 0; k < 7; k++) cfg_chk("R1 attr byte", 8'h59 + 8'(k), 8'h00);
        cfg_chk("R1 smram ctrl", 8'h72, 8'h02);
    endtask

    task automatic t_top_region();
        access("R2 default pci", 32'hF0000, 1'b0);
        cfg_wr(8'h59, 8'h03);
        access("R2 low bits ignored", 32'hF8000, 1'b0);
        cfg_wr(8'h59, 8'h30);
        access("R2 R11 rw read", 32'hFFFFF, 1'b0);
        access("R2 rw write", 32'hF0000, 1'b1);
        cfg_wr(8'h59, 8'h00);
    endtask

    task automatic t_sub_regions();
        for (int i = 0; i < 12; i++) begin
            for (int k = 1; k < 7; k++) cfg_wr(8'h59 + 8'(k), 8'h00);
            cfg_wr(8'h5A + 8'(i >> 1), (i % 2 == 0) ? 8'h03 : 8'h30);
            for (int j = 0; j < 12; j++)
                access("R3 region select", 32'hC0000 + 32'(j) * 32'h4000 + ((j % 2 == 0) ? 32'h0 : 32'h3FFF), 1'b0);
            access("R3 top unaffected", 32'hF1234, 1'b0);
        end
        for (int k = 1; k < 7; k++) cfg_wr(8'h59 + 8'(k), 8'h00);
    endtask

    task automatic t_encoding();
        for (int v = 0; v < 4; v++) begin
            cfg_wr(8'h5C, 8'(v << 4));
            access("R4 R5 read", 32'hD4100, 1'b0);
            access("R4 R5 write", 32'hD4100, 1'b1);
        end
        cfg_wr(8'h5C, 8'h00);
    endtask

    task automatic t_readonly();
        cfg_wr(8'h5F, 8'h10);
        access("R5 write dropped", 32'hEC010, 1'b1);
        @(posedge clk); #1;
        check("R5 single pulse", {5'd0, dram_sel, pci_sel, wr_block}, 8'h00);
        @(negedge clk);
        access("R5 read ok", 32'hEC010, 1'b0);
        cfg_wr(8'h5F, 8'h00);
    endtask

    task automatic t_smram();
        access("R6 default", 32'hA0000, 1'b0);
        cfg_wr(8'h72, 8'h08);
        access("R6 mode off", 32'hBFFFF, 1'b0);
        cfg_wr(8'h72, 8'h40);
        access("R6 open bit", 32'hB0000, 1'b1);
        cfg_wr(8'h72, 8'h00);
        smm_in = 1'b1; repeat (3) @(negedge clk); m_smm = 1'b1;
        access("R6 mode without enable", 32'hA8000, 1'b0);
        cfg_wr(8'h72, 8'h08);
        access("R6 mode and enable", 32'hA8000, 1'b1);
        smm_in = 1'b0; repeat (3) @(negedge clk); m_smm = 1'b0;
        access("R6 mode dropped", 32'hA8000, 1'b0);
    endtask

    task automatic t_sync();
        cfg_wr(8'h72, 8'h08);
        smm_in = 1'b1;
        access("R7 edge1 old", 32'hA0040, 1'b0);
        access("R7 edge2 old", 32'hA0040, 1'b0);
        m_smm = 1'b1;
        access("R7 edge3 new", 32'hA0040, 1'b0);
        smm_in = 1'b0;
        access("R7 fall edge1", 32'hA0040, 1'b0);
        access("R7 fall edge2", 32'hA0040, 1'b0);
        m_smm = 1'b0;
        access("R7 fall edge3", 32'hA0040, 1'b0);
        cfg_wr(8'h72, 8'h02);
    endtask

    task automatic t_outside();
        access("R8 below", 32'h9FFFF, 1'b1);
        access("R8 zero", 32'h0, 1'b0);
        access("R8 above", 32'h100000, 1'b0);
        access("R8 alias high", 32'h1F0000, 1'b1);
        access("R8 alias smram", 32'h80A0000, 1'b0);
    endtask

    task automatic t_memsize();
        cfg_chk("R9 size", 8'h57, 8'd16);
        cfg_wr(8'h57, 8'hAA);
        cfg_chk("R9 write ignored", 8'h57, 8'd16);
        cfg_addr = 8'h57; #1;
        check("R9 saturate", sat_rdata, 8'd255);
        @(negedge clk);
    endtask

    task automatic t_unmapped();
        cfg_wr(8'h58, 8'h5A);
        cfg_chk("R12 0x58", 8'h58, 8'h00);
        cfg_wr(8'h60, 8'hFF);
        cfg_chk("R12 0x60", 8'h60, 8'h00);
        cfg_chk("R12 attr intact", 8'h5F, 8'h00);
        access("R12 no region effect", 32'hEC000, 1'b0);
    endtask

    task automatic t_idle();
        @(posedge clk); #1;
        check("R10 idle", {5'd0, dram_sel, pci_sel, wr_block}, 8'h00);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
        m_smc = 8'h02;
        m_smm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_top_region();
        t_sub_regions();
        t_encoding();
        t_readonly();
        t_smram();
        t_sync();
        t_outside();
        t_memsize();
        t_unmapped();
        t_idle();
        finish_run();
    end

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule